// File: doc/BRIEF.md
# Two-Stage Page Memory-Type Resolver

This block works out the memory attributes that apply to an access under two-stage address translation. It takes the attribute of the physical region being addressed and the two-bit memory-type fields of the guest-physical (G-stage) and guest-virtual (VS-stage) page table entries. Each stage has its own enable. When a stage is enabled and its field holds a nonzero legal value, that field overrides the attribute coming into the stage. The G-stage override of the region attribute gives an intermediate attribute. The VS-stage override of that intermediate attribute gives the final attribute.

Each attribute is a pair of bits: cacheable and strict I/O ordering. Two results are given at once. The final attribute serves ordinary accesses that go through both stages. The intermediate attribute serves accesses that skip the first stage, such as reads of the VS-stage page tables. The block also checks each enabled stage's field for illegal values. When it finds one, it raises a page-fault indication tagged with the stage, and it withholds the attribute-valid strobe. All results are registered one cycle after the request.

Top module: `mtr_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `attrValid` and `faultValid` are 0 and `faultStage` is 0.
- R2: A request presented with `reqValid`=1 gives exactly one of `attrValid` or `faultValid` in the next cycle. A cycle with `reqValid`=0 gives neither in the next cycle.
- R3: The memory-type encodings are: 0 keeps the incoming attribute; 1 (non-cacheable memory) clears both cacheable and I/O-ordering; 2 (I/O) clears cacheable and sets I/O-ordering; 3 is reserved.
- R4: If `gOn`=1, `gLeaf`=1 and `gType` is 1 or 2, the intermediate attribute is the R3 mapping of `gType`. Otherwise the intermediate attribute equals the region attribute (`pmaCacheable`, `pmaIoOrder`).
- R5: If `vsOn`=1, `vsLeaf`=1 and `vsType` is 1 or 2, the final attribute is the R3 mapping of `vsType`. Otherwise the final attribute equals the intermediate attribute.
- R6: The intermediate outputs (`ptCacheable`, `ptIoOrder`) never depend on the VS-stage inputs.
- R7: An enabled stage whose entry is a leaf with type 3 raises a fault.
- R8: An enabled stage whose entry is a non-leaf with any nonzero type raises a fault.
- R9: A faulting request sets `faultValid` and clears `attrValid`. `faultStage` is 1 for a G-stage fault and 2 for a VS-stage fault, and G-stage wins when both stages fault. `faultStage` is 0 whenever `faultValid` is 0.
- R10: When a stage's enable is 0, its type and leaf inputs cause neither an override nor a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request strobe |
| pmaCacheable | input | 1 | Region attribute: cacheable |
| pmaIoOrder | input | 1 | Region attribute: strict I/O ordering |
| gOn | input | 1 | G-stage translation enabled |
| gLeaf | input | 1 | G-stage entry is a leaf |
| gType | input | 2 | G-stage memory-type field |
| vsOn | input | 1 | VS-stage translation enabled |
| vsLeaf | input | 1 | VS-stage entry is a leaf |
| vsType | input | 2 | VS-stage memory-type field |
| attrValid | output | 1 | Attributes valid, no fault |
| finalCacheable | output | 1 | Final attribute: cacheable |
| finalIoOrder | output | 1 | Final attribute: I/O ordering |
| ptCacheable | output | 1 | Intermediate attribute: cacheable |
| ptIoOrder | output | 1 | Intermediate attribute: I/O ordering |
| faultValid | output | 1 | Page fault detected |
| faultStage | output | 2 | Faulting stage: 0 none, 1 G-stage, 2 VS-stage |

## Verification
The hardest case to reach is a fault in both stages at once while both enables are set. Only that case shows the G-stage priority in the stage code. The same applies to disabled stages that hold reserved or non-leaf nonzero values, which must not fault. Random stimulus keeps the enables and the leaf bits high most of the time and draws the type fields uniformly, so reserved values meet active stages often. Directed cases then force the double-fault and the disabled-but-illegal patterns explicitly.

// File: rtl/mtr_pkg.sv
package mtr_pkg;
  localparam int MT_W  = 2;
  localparam int STG_W = 2;

  typedef enum logic [MT_W-1:0] {
    MT_PMA = 2'd0,
    MT_NC  = 2'd1,
    MT_IO  = 2'd2,
    MT_RSV = 2'd3
  } mtype_e;

  typedef enum logic [STG_W-1:0] {
    FS_NONE = 2'd0,
    FS_G    = 2'd1,
    FS_VS   = 2'd2
  } fstage_e;

  typedef struct packed {
    logic cacheable;
    logic ioOrder;
  } attr_t;

  // strobes from control to datapath
  typedef struct packed {
    logic gApply;
    logic vsApply;
    logic capture;
  } strobe_t;
endpackage

// File: rtl/mtr_ctrl.sv
module mtr_ctrl
  import mtr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reqValid,
  input  logic             gOn,
  input  logic             gLeaf,
  input  logic [MT_W-1:0]  gType,
  input  logic             vsOn,
  input  logic             vsLeaf,
  input  logic [MT_W-1:0]  vsType,
  output strobe_t          stb,
  output logic             attrValid,
  output logic             faultValid,
  output logic [STG_W-1:0] faultStage
);
  function automatic logic isBad(logic on, logic leaf, logic [MT_W-1:0] t);
    if (!on) return 1'b0;
    if (leaf) return t == MT_RSV;
    return t != MT_PMA;
  endfunction

  function automatic logic isOverride(logic on, logic leaf, logic [MT_W-1:0] t);
    return on && leaf && (t == MT_NC || t == MT_IO);
  endfunction

  logic gBad, vsBad;
  fstage_e nextStage;

  always_comb begin
    gBad        = isBad(gOn, gLeaf, gType);
    vsBad       = isBad(vsOn, vsLeaf, vsType);
    stb.gApply  = isOverride(gOn, gLeaf, gType);
    stb.vsApply = isOverride(vsOn, vsLeaf, vsType);
    stb.capture = reqValid;
    if (gBad)       nextStage = FS_G;
    else if (vsBad) nextStage = FS_VS;
    else            nextStage = FS_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      attrValid  <= 1'b0;
      faultValid <= 1'b0;
      faultStage <= FS_NONE;
    end else begin
      attrValid  <= reqValid && (nextStage == FS_NONE);
      faultValid <= reqValid && (nextStage != FS_NONE);
      faultStage <= reqValid ? nextStage : FS_NONE;
    end
  end
endmodule

// File: rtl/mtr_dp.sv
module mtr_dp
  import mtr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  strobe_t         stb,
  input  attr_t           pmaAttr,
  input  logic [MT_W-1:0] gType,
  input  logic [MT_W-1:0] vsType,
  output attr_t           interAttr,
  output attr_t           finalAttr
);
  function automatic attr_t mapType(logic [MT_W-1:0] t, attr_t base);
    attr_t r;
    case (t)
      MT_NC:   r = '{cacheable: 1'b0, ioOrder: 1'b0};
      MT_IO:   r = '{cacheable: 1'b0, ioOrder: 1'b1};
      default: r = base;
    endcase
    return r;
  endfunction

  attr_t interNext, finalNext;

  always_comb begin
    interNext = stb.gApply  ? mapType(gType, pmaAttr)   : pmaAttr;
    finalNext = stb.vsApply ? mapType(vsType, interNext) : interNext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      interAttr <= '0;
      finalAttr <= '0;
    end else if (stb.capture) begin
      interAttr <= interNext;
      finalAttr <= finalNext;
    end
  end
endmodule

// File: rtl/mtr_top.sv
module mtr_top
  import mtr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reqValid,
  input  logic       pmaCacheable,
  input  logic       pmaIoOrder,
  input  logic       gOn,
  input  logic       gLeaf,
  input  logic [1:0] gType,
  input  logic       vsOn,
  input  logic       vsLeaf,
  input  logic [1:0] vsType,
  output logic       attrValid,
  output logic       finalCacheable,
  output logic       finalIoOrder,
  output logic       ptCacheable,
  output logic       ptIoOrder,
  output logic       faultValid,
  output logic [1:0] faultStage
);
  strobe_t stb;
  attr_t   pmaAttr, interAttr, finalAttr;

  assign pmaAttr = '{cacheable: pmaCacheable, ioOrder: pmaIoOrder};

  mtr_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid),
    .gOn(gOn), .gLeaf(gLeaf), .gType(gType),
    .vsOn(vsOn), .vsLeaf(vsLeaf), .vsType(vsType),
    .stb(stb), .attrValid(attrValid), .faultValid(faultValid),
    .faultStage(faultStage)
  );

  mtr_dp u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .pmaAttr(pmaAttr),
    .gType(gType), .vsType(vsType),
    .interAttr(interAttr), .finalAttr(finalAttr)
  );

  assign finalCacheable = finalAttr.cacheable;
  assign finalIoOrder   = finalAttr.ioOrder;
  assign ptCacheable    = interAttr.cacheable;
  assign ptIoOrder      = interAttr.ioOrder;
endmodule

// File: rtl/mtr_checker.sv
module mtr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       reqValid,
  input logic       pmaCacheable,
  input logic       gOn,
  input logic       vsOn,
  input logic       vsLeaf,
  input logic [1:0] vsType,
  input logic       attrValid,
  input logic       finalCacheable,
  input logic       finalIoOrder,
  input logic       ptCacheable,
  input logic       faultValid,
  input logic [1:0] faultStage
);
  p_one_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> (attrValid != faultValid));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> (!attrValid && !faultValid));

  p_fault_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (faultValid == (faultStage != 2'd0)));

  p_vs_io_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && vsOn && vsLeaf && vsType == 2'd2) |=>
      (!attrValid || (finalIoOrder && !finalCacheable)));

  p_stages_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !gOn && !vsOn) |=>
      (attrValid && ptCacheable == $past(pmaCacheable)
       && finalCacheable == $past(pmaCacheable)));
endmodule

bind mtr_top mtr_checker u_chk (
  .clk(clk), .rst_n(rst_n), .reqValid(reqValid),
  .pmaCacheable(pmaCacheable), .gOn(gOn), .vsOn(vsOn),
  .vsLeaf(vsLeaf), .vsType(vsType), .attrValid(attrValid),
  .finalCacheable(finalCacheable), .finalIoOrder(finalIoOrder),
  .ptCacheable(ptCacheable), .faultValid(faultValid),
  .faultStage(faultStage)
);

// File: tb/mtr_top_bench.sv
`timescale 1ns/1ps
module mtr_top_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reqValid = 1'b0, pmaCacheable = 1'b0, pmaIoOrder = 1'b0;
  logic gOn = 1'b0, gLeaf = 1'b0, vsOn = 1'b0, vsLeaf = 1'b0;
  logic [1:0] gType = 2'd0, vsType = 2'd0;
  logic attrValid, finalCacheable, finalIoOrder, ptCacheable, ptIoOrder, faultValid;
  logic [1:0] faultStage;

  int nChecks = 0, nFails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  mtr_top u_mtr_top (.*);

  task automatic chk(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference: returns {cacheable, ioOrder}
  function automatic logic [1:0] mapRef(logic [1:0] t, logic [1:0] base);
    if (t == 2'd1) return 2'b00;
    if (t == 2'd2) return 2'b01;
    return base;
  endfunction

  function automatic logic badRef(logic on, logic leaf, logic [1:0] t);
    return on && (leaf ? (t == 2'd3) : (t != 2'd0));
  endfunction

  task automatic apply(logic rv, logic pc, logic pio, logic go, logic gl, logic [1:0] gt,
                       logic vo, logic vl, logic [1:0] vt, string tag);
    logic [1:0] pma, inter, fin;
    logic gBad, vBad;
    int stage;
    reqValid = rv; pmaCacheable = pc; pmaIoOrder = pio;
    gOn = go; gLeaf = gl; gType = gt; vsOn = vo; vsLeaf = vl; vsType = vt;
    pma   = {pc, pio};
    inter = (go && gl) ? mapRef(gt, pma) : pma;
    fin   = (vo && vl) ? mapRef(vt, inter) : inter;
    gBad  = badRef(go, gl, gt);
    vBad  = badRef(vo, vl, vt);
    stage = !rv ? 0 : gBad ? 1 : vBad ? 2 : 0;
    @(negedge clk);
    chk({tag, " R2 attrValid"}, attrValid, rv && stage == 0);
    chk({tag, " R9 faultValid"}, faultValid, stage != 0);
    chk({tag, " R9 faultStage"}, faultStage, stage);
    if (rv && stage == 0) begin
      chk({tag, " R4 intermediate"}, {ptCacheable, ptIoOrder}, inter);
      chk({tag, " R5 final"}, {finalCacheable, finalIoOrder}, fin);
    end
  endtask

  initial begin
    #2.5;
    chk("R1 attrValid in reset", attrValid, 0);
    chk("R1 faultValid in reset", faultValid, 0);
    chk("R1 faultStage in reset", faultStage, 0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 attrValid after reset", attrValid, 0);
    chk("R1 faultValid after reset", faultValid, 0);

    // R3 encodings through the VS stage on a cacheable region
    apply(1, 1, 0, 0, 1, 0, 1, 1, 2'd0, "R3 type0");
    apply(1, 1, 0, 0, 1, 0, 1, 1, 2'd1, "R3 type1");
    apply(1, 1, 0, 0, 1, 0, 1, 1, 2'd2, "R3 type2");
    // R4 G-stage override, VS passes
    apply(1, 1, 0, 1, 1, 2'd2, 1, 1, 2'd0, "R4 g io");
    // R6 intermediate unaffected by VS override
    apply(1, 1, 0, 1, 1, 2'd0, 1, 1, 2'd2, "R6 vs io");
    chk("R6 intermediate keeps region", {ptCacheable, ptIoOrder}, 2'b10);
    apply(1, 0, 1, 1, 1, 2'd1, 1, 1, 2'd2, "R6 chain");
    chk("R6 intermediate from g stage", {ptCacheable, ptIoOrder}, 2'b00);
    // R7 reserved leaf
    apply(1, 1, 0, 1, 1, 2'd3, 0, 1, 2'd0, "R7 g rsv");
    apply(1, 1, 0, 1, 1, 2'd0, 1, 1, 2'd3, "R7 vs rsv");
    // R8 nonleaf nonzero
    apply(1, 1, 0, 1, 0, 2'd1, 1, 1, 2'd0, "R8 g nonleaf");
    apply(1, 1, 0, 0, 1, 0, 1, 0, 2'd2, "R8 vs nonleaf");
    apply(1, 1, 0, 1, 0, 2'd0, 1, 0, 2'd0, "R8 nonleaf zero");
    // R9 both faulting: G wins
    apply(1, 1, 0, 1, 1, 2'd3, 1, 0, 2'd1, "R9 double");
    chk("R9 double fault code", faultStage, 1);
    // R10 disabled stages with illegal values
    apply(1, 1, 1, 0, 1, 2'd3, 0, 0, 2'd2, "R10 off illegal");
    chk("R10 final equals region", {finalCacheable, finalIoOrder}, 2'b11);
    apply(1, 0, 0, 0, 1, 2'd2, 0, 1, 2'd1, "R10 off legal");
    chk("R10 no override", {ptCacheable, ptIoOrder}, 2'b00);
    // R2 idle
    apply(0, 1, 0, 1, 1, 2'd3, 1, 1, 2'd3, "R2 idle");

    process::self().srandom(32'h5eed_1234);
    for (int i = 0; i < 3000; i++) begin
      apply(($urandom % 8) != 0, $urandom % 2, $urandom % 2,
            ($urandom % 4) != 0, ($urandom % 4) != 0, 2'($urandom % 4),
            ($urandom % 4) != 0, ($urandom % 4) != 0, 2'($urandom % 4), "rand");
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog R2 actual=hung expected=done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule